// File: doc/BRIEF.md
# Oversampled Decimation Averaging Filter

This block sits behind a sigma-delta capacitance front end and reduces its raw modulator stream to one 16-bit signed result per conversion stage. The stage opens with a start strobe. A 2-bit decimation code, captured at that strobe, picks the oversampling ratio. Each stage sums three times that ratio in samples and then divides the sum by the sample count.

At a nominal 250 kHz sample rate, the low ratio gives a result about every 1.536 ms and the high ratio about every 3.072 ms. A higher ratio trades output rate for lower noise. The two unused decimation codes are rejected: the block raises an error flag and produces no result. A new start strobe always wins over an accumulation or division in progress.

Top module: `decim_avg_filter`

## Requirements
- R1: Decimation code 2'b00 makes a stage average exactly 768 accepted samples. Code 2'b01 makes it average exactly 384 accepted samples.
- R2: The result is the signed sum of the stage's samples divided by the sample count, truncated toward zero. It is given as a 16-bit two's-complement value.
- R3: Stages whose samples are all full-scale positive (32767) or all full-scale negative (-32768) return that same value, with no wrap of the running sum.
- R4: A start strobe with code 2'b10 or 2'b11 sets err_o from the next cycle onward. err_o stays high until a start strobe with a legal code. While err_o is high, no sample is accumulated and done_o never pulses.
- R5: A start strobe clears the running sum and the sample count. It also cancels any stage that is still accumulating or dividing, and that cancelled stage never produces a result.
- R6: A sample that is valid in the same cycle as a start strobe is the first sample of the new stage. If that cycle would also have supplied the last sample of the old stage, the start strobe wins.
- R7: The decimation code is used only in the cycle of the start strobe. Changes to dec_code_i during a stage have no effect on that stage's sample count.
- R8: done_o is high for exactly one cycle, and result_o carries the new result in that same cycle. result_o keeps its value until the next done_o.
- R9: Cycles with smp_vld_i low are not counted. Samples that arrive after a stage's last sample and before the next start strobe are ignored.
- R10: While rst is high, and on leaving reset, result_o is 0, done_o is 0 and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stage_start_i | input | 1 | Start-of-stage strobe |
| dec_code_i | input | 2 | Decimation code, captured on the strobe |
| smp_vld_i | input | 1 | Sample valid qualifier |
| smp_i | input | 16 | Signed modulator sample |
| result_o | output | 16 | Signed averaged stage result |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Reserved decimation code seen at last start |

## Verification
Two functions can fall in the same cycle: the start strobe of a new stage, and the acceptance of the last sample that would end the current stage. The bench provokes this by feeding one sample fewer than the stage needs. In the very next cycle it raises the start strobe together with a valid sample of a different value, and then supplies the rest of the new stage. The case is judged correct only if exactly one done pulse follows and it carries the average of the new stage's constant value. That shows the old stage was dropped and the shared sample was counted as the new stage's first.

// File: rtl/davg_pkg.sv
package davg_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACC  = 1'b1
  } seq_state_t;

  localparam logic [1:0] DEC_HI = 2'b00;
  localparam logic [1:0] DEC_LO = 2'b01;

  function automatic logic code_legal(input logic [1:0] c);
    return (c == DEC_HI) || (c == DEC_LO);
  endfunction

endpackage

// File: rtl/davg_seq.sv
module davg_seq
  import davg_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int N_HI  = 768,
  parameter int N_LO  = 384
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       code_i,
  input  logic             vld_i,
  output logic             take_o,
  output logic             last_o,
  output logic             err_o,
  output logic [CNT_W-1:0] divisor_o
);

  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] n_sel;
  logic             code_ok;
  logic             err_q;

  assign code_ok   = code_legal(code_i);
  assign n_sel     = (code_i == DEC_HI) ? CNT_W'(N_HI) : CNT_W'(N_LO);
  assign take_o    = vld_i && (start_i ? code_ok : (st_q == ST_ACC));
  assign last_o    = !start_i && (st_q == ST_ACC) && vld_i && (cnt_q == n_q - 1'b1);
  assign err_o     = err_q;
  assign divisor_o = n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      n_q   <= CNT_W'(N_HI);
      err_q <= 1'b0;
    end else if (start_i) begin
      err_q <= !code_ok;
      st_q  <= code_ok ? ST_ACC : ST_IDLE;
      n_q   <= n_sel;
      cnt_q <= (vld_i && code_ok) ? CNT_W'(1) : '0;
    end else if ((st_q == ST_ACC) && vld_i) begin
      if (last_o) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_ACC) && !start_i) |=> $stable(n_q));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ACC) |-> (cnt_q < n_q));

  // R4
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (st_q == ST_IDLE));

endmodule

// File: rtl/davg_accum.sv
module davg_accum #(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 26
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                take_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  output logic [ACC_W-1:0]    sum_o
);

  localparam int EXT_W = ACC_W + 1 - SAMPLE_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;
  logic [ACC_W:0]   addend;
  logic [ACC_W:0]   wide;

  assign base   = clr_i ? '0 : acc_q;
  assign addend = take_i ? {{EXT_W{smp_i[SAMPLE_W-1]}}, smp_i} : '0;
  assign wide   = {base[ACC_W-1], base} + addend;
  assign sum_o  = wide[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (clr_i || take_i) begin
      acc_q <= sum_o;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    take_i |-> (wide[ACC_W] == wide[ACC_W-1]));

endmodule

// File: rtl/davg_div.sv
module davg_div #(
  parameter int ACC_W    = 26,
  parameter int CNT_W    = 10,
  parameter int RESULT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic                abort_i,
  input  logic [ACC_W-1:0]    dividend_i,
  input  logic [CNT_W-1:0]    divisor_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                done_o
);

  localparam int STEP_W = $clog2(ACC_W + 1);

  logic                busy_q;
  logic [STEP_W-1:0]   step_q;
  logic [ACC_W-1:0]    quot_q;
  logic [CNT_W-1:0]    rem_q;
  logic [CNT_W-1:0]    div_q;
  logic                neg_q;
  logic [ACC_W-1:0]    mag;
  logic [CNT_W:0]      rem_sh;
  logic                fits;
  logic [CNT_W:0]      rem_nx;
  logic [RESULT_W-1:0] q_trunc;

  assign mag     = dividend_i[ACC_W-1] ? (~dividend_i + 1'b1) : dividend_i;
  assign rem_sh  = {rem_q, quot_q[ACC_W-1]};
  assign fits    = rem_sh >= {1'b0, div_q};
  assign rem_nx  = fits ? (rem_sh - {1'b0, div_q}) : rem_sh;
  assign q_trunc = quot_q[RESULT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      step_q   <= '0;
      quot_q   <= '0;
      rem_q    <= '0;
      div_q    <= '0;
      neg_q    <= 1'b0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (load_i) begin
        busy_q <= 1'b1;
        step_q <= STEP_W'(ACC_W);
        quot_q <= mag;
        rem_q  <= '0;
        div_q  <= divisor_i;
        neg_q  <= dividend_i[ACC_W-1];
      end else if (busy_q) begin
        if (step_q != '0) begin
          rem_q  <= rem_nx[CNT_W-1:0];
          quot_q <= {quot_q[ACC_W-2:0], fits};
          step_q <= step_q - 1'b1;
        end else begin
          result_o <= neg_q ? (~q_trunc + 1'b1) : q_trunc;
          done_o   <= 1'b1;
          busy_q   <= 1'b0;
        end
      end
    end
  end

  // R2
  rem_top_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (step_q != '0)) |-> !rem_nx[CNT_W]);

  // R2
  quot_range_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (step_q == '0)) |-> (quot_q <= (ACC_W'(1) << (RESULT_W - 1))));

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

endmodule

// File: rtl/decim_avg_filter.sv
module decim_avg_filter #(
  parameter int SAMPLE_W = 16,
  parameter int RESULT_W = 16,
  parameter int RATIO_HI = 256,
  parameter int RATIO_LO = 128,
  parameter int SUM_MULT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stage_start_i,
  input  logic [1:0]          dec_code_i,
  input  logic                smp_vld_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                done_o,
  output logic                err_o
);

  localparam int N_HI  = SUM_MULT * RATIO_HI;
  localparam int N_LO  = SUM_MULT * RATIO_LO;
  localparam int CNT_W = $clog2(N_HI + 1);
  localparam int ACC_W = SAMPLE_W + CNT_W;

  logic             take;
  logic             last;
  logic [CNT_W-1:0] divisor;
  logic [ACC_W-1:0] sum_nx;

  davg_seq #(
    .CNT_W (CNT_W),
    .N_HI  (N_HI),
    .N_LO  (N_LO)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (stage_start_i),
    .code_i    (dec_code_i),
    .vld_i     (smp_vld_i),
    .take_o    (take),
    .last_o    (last),
    .err_o     (err_o),
    .divisor_o (divisor)
  );

  davg_accum #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
  ) u_accum (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (stage_start_i),
    .take_i (take),
    .smp_i  (smp_i),
    .sum_o  (sum_nx)
  );

  davg_div #(
    .ACC_W    (ACC_W),
    .CNT_W    (CNT_W),
    .RESULT_W (RESULT_W)
  ) u_div (
    .clk        (clk),
    .rst        (rst),
    .load_i     (last),
    .abort_i    (stage_start_i),
    .dividend_i (sum_nx),
    .divisor_i  (divisor),
    .result_o   (result_o),
    .done_o     (done_o)
  );

  // R4
  err_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !done_o);

endmodule

// File: tb/decim_avg_filter_tb.sv
module decim_avg_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_HI = 768;
  localparam int N_LO = 384;

  // fields: code[35:34] ramp[33] gap[32] base[31:16] delta[15:0]
  localparam logic [35:0] VECS [0:7] = '{
    {2'b00, 1'b0, 1'b0, 16'(5),      16'(3)},
    {2'b01, 1'b0, 1'b1, 16'(-5),     16'(-3)},
    {2'b00, 1'b0, 1'b0, 16'(32767),  16'(0)},
    {2'b00, 1'b0, 1'b1, 16'(-32768), 16'(0)},
    {2'b01, 1'b0, 1'b1, 16'(32767),  16'(0)},
    {2'b01, 1'b0, 1'b0, 16'(32767),  16'(-1)},
    {2'b00, 1'b1, 1'b0, 16'(-300),   16'(1)},
    {2'b01, 1'b1, 1'b1, 16'(100),    16'(-1)}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stage_start = 1'b0;
  logic [1:0]  dec_code = 2'b00;
  logic        smp_vld = 1'b0;
  logic [15:0] smp = '0;
  logic [15:0] result;
  logic        done;
  logic        err;

  int total = 0;
  int fails = 0;
  int done_cnt = 0;

  decim_avg_filter u_dut (
    .clk           (clk),
    .rst           (rst),
    .stage_start_i (stage_start),
    .dec_code_i    (dec_code),
    .smp_vld_i     (smp_vld),
    .smp_i         (smp),
    .result_o      (result),
    .done_o        (done),
    .err_o         (err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic begin_stage(input logic [1:0] code);
    stage_start = 1'b1;
    dec_code    = code;
    @(negedge clk);
    stage_start = 1'b0;
  endtask

  task automatic push(input int v);
    smp_vld = 1'b1;
    smp     = v[15:0];
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic wait_done(input int exp, input string tag);
    int n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done seen"}, int'(done), 1);
    chk({tag, " result"}, int'($signed(result)), exp);
    @(negedge clk);
    chk({tag, " done one cycle (R8)"}, int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int dc0;
    int r0;
    repeat (4) @(negedge clk);
    chk("R10 result in reset", int'(result), 0);
    chk("R10 done in reset", int'(done), 0);
    chk("R10 err in reset", int'(err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 result after reset", int'(result), 0);

    // R1 R2 R3 R9: vector table
    for (int k = 0; k < 8; k++) begin
      logic [35:0] v;
      int n, base, delta, s;
      longint sum;
      v     = VECS[k];
      n     = (v[35:34] == 2'b00) ? N_HI : N_LO;
      base  = int'($signed(v[31:16]));
      delta = int'($signed(v[15:0]));
      sum   = 0;
      begin_stage(v[35:34]);
      for (int i = 0; i < n; i++) begin
        s = v[33] ? (base + i * delta) : (base + ((i % 2 == 1) ? delta : 0));
        sum += s;
        if (v[32] && (i % 4 == 0)) @(negedge clk);
        push(s);
      end
      wait_done(int'(sum / longint'(n)), $sformatf("R1 R2 R3 R9 vec%0d", k));
    end

    // R4: reserved codes
    dc0 = done_cnt;
    begin_stage(2'b10);
    chk("R4 err after code 10", int'(err), 1);
    for (int i = 0; i < 800; i++) push(100);
    repeat (40) @(negedge clk);
    chk("R4 no done for code 10", done_cnt, dc0);
    begin_stage(2'b11);
    chk("R4 err after code 11", int'(err), 1);
    for (int i = 0; i < 400; i++) push(100);
    repeat (40) @(negedge clk);
    chk("R4 no done for code 11", done_cnt, dc0);
    chk("R4 err held", int'(err), 1);
    begin_stage(2'b01);
    chk("R4 err cleared by legal start", int'(err), 0);
    for (int i = 0; i < N_LO; i++) push(4);
    wait_done(4, "R4 recovery");

    // R5: abort mid-stage
    dc0 = done_cnt;
    begin_stage(2'b00);
    for (int i = 0; i < 300; i++) push(1000);
    begin_stage(2'b01);
    for (int i = 0; i < N_LO; i++) push(-7);
    wait_done(-7, "R5 abort");
    repeat (2) @(negedge clk);
    chk("R5 single done", done_cnt, dc0 + 1);

    // R6: start strobe and last sample in the same cycle
    dc0 = done_cnt;
    begin_stage(2'b01);
    for (int i = 0; i < N_LO - 1; i++) push(50);
    stage_start = 1'b1;
    dec_code    = 2'b01;
    smp_vld     = 1'b1;
    smp         = 16'(9);
    @(negedge clk);
    stage_start = 1'b0;
    smp_vld     = 1'b0;
    for (int i = 0; i < N_LO - 1; i++) push(9);
    wait_done(9, "R6 start wins");
    repeat (2) @(negedge clk);
    chk("R6 single done", done_cnt, dc0 + 1);

    // R7: code change mid-stage ignored
    begin_stage(2'b01);
    dec_code = 2'b00;
    for (int i = 0; i < N_LO; i++) push(i);
    wait_done(191, "R7 code held");

    // R9: samples after completion ignored
    dc0 = done_cnt;
    r0  = int'($signed(result));
    for (int i = 0; i < 50; i++) push(30000);
    repeat (60) @(negedge clk);
    chk("R9 no done after stage end", done_cnt, dc0);
    chk("R9 result unchanged (R8 hold)", int'($signed(result)), r0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule